// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Buffer

This block is the slave side of a two-wire serial memory. It holds 512 bytes, split into two independent 256-byte blocks. SCL and SDA reach it already synchronised to the system clock. SDA is open drain: the block only pulls the line low through `sda_oe_o`. The block detects bus conditions and decodes a control byte that selects a block and a direction. It then takes a word address, or it streams read data back to the master.

Written bytes do not go straight into the array. They collect in a sixteen-entry ring that keeps only the most recent bytes. The Stop that closes a write starts a modelled programming cycle of `PROG_CYCLES` system clocks. In the final clocks of that cycle the ring is copied into the array, one byte per clock. While the cycle runs the block sends no acknowledge, so a master finds out that the write has finished by polling with control bytes until one of them is acknowledged.

Top module: `twi_eeprom_slave`

## Requirements
- R1: An SDA fall while SCL is high (Start) abandons any transfer, even one stopped partway through a byte, and the next eight bits are decoded as a control byte. An SDA rise while SCL is high (Stop) returns the block to idle.
- R2: A control byte is acknowledged only if its upper nibble is 1010. Bits 3:2 are ignored, bit 1 selects the 256-byte block and bit 0 set to 1 requests a read. After any other control byte the block stays silent, acknowledging nothing, until the next Start.
- R3: The block acknowledges each accepted byte by pulling SDA low. It pulls from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth pulse.
- R4: The block changes its SDA drive only just after an SCL fall, never while SCL is high.
- R5: A read sends the byte at (block, pointer) MSB first. The pointer then increments and wraps within the selected block, and an acknowledge from the master continues the read with the next byte.
- R6: If the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next Start.
- R7: A write is a control byte with bit 0 clear, a word address and data bytes. A Stop after at least one complete data byte starts a programming cycle. The stored bytes land at consecutive addresses starting at the word address, wrapping within the block.
- R8: If a write carries more than sixteen data bytes, only the last sixteen are kept, and the oldest of them lands at the word address.
- R9: During a programming cycle no byte is acknowledged, control bytes included. Normal responses resume once the cycle ends.
- R10: A word address with no data byte starts no programming cycle. It only loads the pointer, so a Start followed by a read control byte returns data from that address.
- R11: After reset, SDA is released, every array byte reads 0xFF, the pointer is 0 and no programming cycle is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data line, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest condition to reach is a control byte arriving while a programming cycle is running. To hit it, the stimulus issues a Start and a control byte right after the Stop that ends a write. It sets the cycle length long enough to cover the whole control byte, checks for the missing acknowledge, and then repeats the read once the cycle has run out. A second hard case is the overflowing write: twenty data bytes go out in a single write, and a seventeen-byte sequential read then shows that the first four were discarded and that nothing landed past the sixteenth address. The Start inside a byte is produced by cutting a data byte after four bits.

// File: rtl/twi_eeprom_pkg.sv
`timescale 1ns/1ps
package twi_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WR,
    ST_RD
  } twi_st_e;

  localparam logic [3:0] CTRL_TAG = 4'b1010;
  localparam int         BYTE_W   = 8;
endpackage

// File: rtl/twi_bus_cond.sv
`timescale 1ns/1ps
module twi_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;

  // R1: a bus condition needs SCL high in both samples, so it never meets an SCL edge
  a_r1_cond_not_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/twi_wbuf.sv
`timescale 1ns/1ps
module twi_wbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
  output logic [$clog2(DEPTH+1)-1:0] fill_o,
  output logic [W-1:0]               dout_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C   = CW'(DEPTH);
  localparam logic [IW-1:0] LAST_I   = IW'(DEPTH - 1);
  localparam logic [IW:0]   DEPTH_WR = (IW + 1)'(DEPTH);

  logic [W-1:0]  ring_q [DEPTH];
  logic [IW-1:0] head_q;
  logic [CW-1:0] fill_q;
  logic [IW-1:0] oldest;
  logic [IW:0]   sum;
  logic [IW-1:0] rd_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      fill_q <= '0;
    end else if (push_i) begin
      head_q <= (head_q == LAST_I) ? '0 : head_q + 1'b1;
      if (fill_q != FULL_C) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) ring_q[head_q] <= din_i;
  end

  // once full, the oldest kept byte sits at the write head
  always_comb begin
    oldest  = (fill_q == FULL_C) ? head_q : '0;
    sum     = {1'b0, oldest} + {1'b0, rd_idx_i};
    rd_slot = (sum >= DEPTH_WR) ? IW'(sum - DEPTH_WR) : IW'(sum);
  end

  assign dout_o = ring_q[rd_slot];
  assign fill_o = fill_q;

  a_r8_fill_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FULL_C);
  a_r8_full_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == FULL_C && push_i && !clear_i) |=> (fill_q == FULL_C));
endmodule

// File: rtl/twi_mem_array.sv
`timescale 1ns/1ps
module twi_mem_array #(
  parameter int AW = 9,
  parameter int W  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [W-1:0] cell_q [WORDS];

  // erased cells read as all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) cell_q[i] <= '1;
    end else if (we_i) begin
      cell_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/twi_prog_seq.sv
`timescale 1ns/1ps
module twi_prog_seq #(
  parameter int CYCLES = 5000,
  parameter int DEPTH  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       go_i,
  input  logic [$clog2(DEPTH+1)-1:0] fill_i,
  output logic                       busy_o,
  output logic                       copy_en_o,
  output logic [$clog2(DEPTH)-1:0]   copy_idx_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(CYCLES + 1);
  localparam logic [TW-1:0] TMR_LOAD = TW'(CYCLES - 1);

  logic          busy_q;
  logic [TW-1:0] tmr_q;
  logic [CW-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      n_q    <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        tmr_q  <= TMR_LOAD;
        n_q    <= fill_i;
      end
    end else if (tmr_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  // the copy fills the final n clocks of the cycle, oldest byte first
  assign copy_en_o  = busy_q && (32'(tmr_q) < 32'(n_q));
  assign copy_idx_o = IW'(32'(n_q) - 32'd1 - 32'(tmr_q));
  assign busy_o     = busy_q;

  a_r7_copy_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_en_o |-> (busy_o && n_q != '0));
endmodule

// File: rtl/twi_eeprom_slave.sv
`timescale 1ns/1ps
module twi_eeprom_slave #(
  parameter int BLK_W       = 1,
  parameter int BUF_DEPTH   = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import twi_eeprom_pkg::*;

  localparam int MEM_AW = BLK_W + BYTE_W;
  localparam int BUF_IW = $clog2(BUF_DEPTH);
  localparam int BUF_CW = $clog2(BUF_DEPTH + 1);

  logic start, stop, scl_rise, scl_fall;
  logic prog_busy, copy_en;
  logic [BUF_IW-1:0] copy_idx;
  logic [BUF_CW-1:0] buf_fill;
  logic [BYTE_W-1:0] buf_dout, rdata;

  twi_eeprom_pkg::twi_st_e state_q, nxt_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, tx_q, ptr_q, base_q;
  logic [BLK_W-1:0]  blk_q;
  logic              oe_q, mack_q;

  logic       byte_end, tag_ok, ack_ok, buf_clr, buf_push, prog_go;
  logic [2:0] tx_idx;

  twi_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  always_comb begin
    byte_end = scl_fall && (bit_cnt_q == 4'd8) &&
               (state_q == ST_CTRL || state_q == ST_ADDR || state_q == ST_WR);
    tag_ok   = (shreg_q[7:4] == CTRL_TAG);
    unique case (state_q)
      ST_CTRL:       ack_ok = !prog_busy && tag_ok;
      ST_ADDR, ST_WR: ack_ok = !prog_busy;
      default:       ack_ok = 1'b0;
    endcase
    buf_clr  = byte_end && (state_q == ST_CTRL) && ack_ok && !shreg_q[0];
    buf_push = byte_end && (state_q == ST_WR) && ack_ok;
    prog_go  = stop && (state_q == ST_WR) && (buf_fill != '0) && !prog_busy;
    tx_idx   = 3'(4'd7 - bit_cnt_q);
  end

  twi_wbuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_wbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (buf_clr),
    .push_i  (buf_push),
    .din_i   (shreg_q),
    .rd_idx_i(copy_idx),
    .fill_o  (buf_fill),
    .dout_o  (buf_dout)
  );

  twi_prog_seq #(.CYCLES(PROG_CYCLES), .DEPTH(BUF_DEPTH)) u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (prog_go),
    .fill_i    (buf_fill),
    .busy_o    (prog_busy),
    .copy_en_o (copy_en),
    .copy_idx_o(copy_idx)
  );

  twi_mem_array #(.AW(MEM_AW), .W(BYTE_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (copy_en),
    .waddr_i({blk_q, base_q + BYTE_W'(copy_idx)}),
    .wdata_i(buf_dout),
    .raddr_i({blk_q, ptr_q}),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      base_q    <= '0;
      blk_q     <= '0;
      oe_q      <= 1'b0;
      mack_q    <= 1'b0;
    end else if (start) begin
      state_q   <= ST_CTRL;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt_q != 4'd9) bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_i};
        if (state_q == ST_RD && bit_cnt_q == 4'd8) mack_q <= ~sda_i;
      end
      if (scl_fall) begin
        if (state_q == ST_RD) begin
          if (bit_cnt_q >= 4'd1 && bit_cnt_q <= 4'd7) begin
            oe_q <= ~tx_q[tx_idx];
          end else if (bit_cnt_q == 4'd8) begin
            oe_q  <= 1'b0;
            ptr_q <= ptr_q + 1'b1;
          end else if (bit_cnt_q == 4'd9) begin
            if (mack_q) begin
              tx_q      <= rdata;
              oe_q      <= ~rdata[7];
              bit_cnt_q <= '0;
            end else begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end
          end
        end else if (bit_cnt_q == 4'd8) begin
          if (ack_ok) begin
            oe_q <= 1'b1;
            unique case (state_q)
              ST_CTRL: begin
                blk_q <= shreg_q[BLK_W:1];
                nxt_q <= shreg_q[0] ? ST_RD : ST_ADDR;
              end
              ST_ADDR: begin
                ptr_q  <= shreg_q;
                base_q <= shreg_q;
                nxt_q  <= ST_WR;
              end
              default: nxt_q <= ST_WR;
            endcase
          end else begin
            state_q <= ST_IDLE;
          end
        end else if (bit_cnt_q == 4'd9) begin
          oe_q      <= 1'b0;
          bit_cnt_q <= '0;
          state_q   <= nxt_q;
          if (nxt_q == ST_RD) begin
            tx_q <= rdata;
            oe_q <= ~rdata[7];
          end
        end
      end
    end
  end

  assign sda_oe_o = oe_q;

  a_r4_drive_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> $past(scl_fall));
  a_r9_silent_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy |-> !oe_q);
  a_r7_prog_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_busy) |-> $past(stop));
  a_r6_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  a_r3_ack_after_eighth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oe_q) && state_q != ST_RD) |-> (bit_cnt_q == 4'd8));
endmodule

// File: tb/twi_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module twi_eeprom_slave_tb_top;
  localparam int HP   = 8;
  localparam int PROG = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  twi_eeprom_slave #(.BLK_W(1), .BUF_DEPTH(16), .PROG_CYCLES(PROG)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  int r4_viol = 0;
  logic [7:0] model [512];
  logic [7:0] exp_q [$];
  logic [7:0] wq [32];
  logic [7:0] rx_byte;
  event rx_ev;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R4 monitor: the drive must not move while SCL stays high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) r4_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
  end

  // scoreboard monitor: each byte the master receives is compared with the expected queue
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected read byte", rx_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_byte == e, "R5 read data", rx_byte, e);
      end
    end
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b0; hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp();
      scl_m = 1'b1; hp();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hp();
    scl_m = 1'b1;
    repeat (HP / 2) @(negedge clk);
    ack = !sda_bus;
    repeat (HP / 2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv(input bit mack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hp();
      scl_m = 1'b1;
      repeat (HP / 2) @(negedge clk);
      b[i] = sda_bus;
      repeat (HP / 2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = !mack; hp();
    scl_m = 1'b1; hp();
    scl_m = 1'b0;
    rx_byte = b;
    ->rx_ev;
  endtask

  function automatic int midx(input bit blk, input int a);
    return (blk ? 256 : 0) + (a & 255);
  endfunction

  // write n bytes from wq; the model keeps the last sixteen (R7, R8)
  task automatic wr(input bit blk, input logic [7:0] a, input int n, input bit wait_done);
    bit ack;
    int first;
    bstart();
    send({4'hA, 2'b00, blk, 1'b0}, ack); check(ack, "R2 write control ack", ack, 1);
    send(a, ack);                        check(ack, "R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send(wq[k], ack);                  check(ack, "R3 data ack", ack, 1);
    end
    bstop();
    check(sda_oe == 1'b0, "R3 released after last ack", sda_oe, 0);
    first = (n > 16) ? n - 16 : 0;
    for (int k = first; k < n; k++) model[midx(blk, int'(a) + k - first)] = wq[k];
    if (wait_done) repeat (PROG + 20) @(negedge clk);
  endtask

  // random read: address write, repeated Start, read n bytes with NACK on the last
  task automatic rd(input bit blk, input logic [7:0] a, input int n);
    bit ack;
    bstart();
    send({4'hA, 2'b00, blk, 1'b0}, ack); check(ack, "R10 control ack", ack, 1);
    send(a, ack);                        check(ack, "R10 address ack", ack, 1);
    bstart();
    send({4'hA, 2'b01, blk, 1'b1}, ack); check(ack, "R2 read control ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[midx(blk, int'(a) + k)]);
      recv(k != n - 1);
    end
    hp();
    check(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    bstop();
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R11 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R11 SDA released after reset", sda_oe, 0);

    // R11/R5: current-address read from reset reads erased byte at pointer 0
    bstart();
    send(8'hA1, ack); check(ack, "R2 control ack", ack, 1);
    exp_q.push_back(8'hFF);
    recv(1'b0);
    hp();
    check(sda_oe == 1'b0, "R6 silent after NACK", sda_oe, 0);
    bstop();

    // R2: wrong tag gets no ack, and the block stays silent until the next Start
    bstart();
    send(8'h51, ack); check(!ack, "R2 bad tag ignored", ack, 0);
    send(8'h00, ack); check(!ack, "R2 silent until Start", ack, 0);
    bstop();

    // R7/R9: write three bytes, then poll at once while programming
    wq[0] = 8'h11; wq[1] = 8'h22; wq[2] = 8'h33;
    wr(1'b0, 8'h10, 3, 1'b0);
    bstart();
    send(8'hA0, ack); check(!ack, "R9 no ack while programming", ack, 0);
    bstop();
    repeat (PROG + 20) @(negedge clk);
    rd(1'b0, 8'h10, 3);

    // R10: address only, no programming, pointer loaded
    bstart();
    send(8'hA0, ack); check(ack, "R10 control ack", ack, 1);
    send(8'h40, ack); check(ack, "R10 address ack", ack, 1);
    bstop();
    bstart();
    send(8'hA1, ack); check(ack, "R10 not busy after address-only write", ack, 1);
    exp_q.push_back(model[8'h40]);
    recv(1'b0);
    bstop();

    // R7/R5: wrap within block 1, and block 0 unaffected
    wq[0] = 8'h5A; wq[1] = 8'h6B; wq[2] = 8'h7C;
    wr(1'b1, 8'hFE, 3, 1'b1);
    rd(1'b1, 8'hFE, 4);
    rd(1'b0, 8'hFF, 2);

    // R8: twenty bytes, only the last sixteen kept
    for (int k = 0; k < 20; k++) wq[k] = 8'hC0 + 8'(k);
    wr(1'b0, 8'h80, 20, 1'b1);
    rd(1'b0, 8'h80, 17);

    // R1: Start in the middle of a data byte aborts the write
    bstart();
    send(8'hA0, ack); check(ack, "R1 control ack", ack, 1);
    send(8'h20, ack); check(ack, "R1 address ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; hp();
      scl_m = 1'b1; hp();
      scl_m = 1'b0;
    end
    bstart();
    send(8'hA1, ack); check(ack, "R1 control decoded after mid-byte Start", ack, 1);
    exp_q.push_back(model[8'h20]);
    recv(1'b0);
    bstop();
    // no programming started; R5 pointer advanced to 0x21
    bstart();
    send(8'hA1, ack); check(ack, "R1 no programming after aborted write", ack, 1);
    exp_q.push_back(model[8'h21]);
    recv(1'b0);
    bstop();

    hp();
    check(r4_viol == 0, "R4 drive stable while SCL high", r4_viol, 0);
    check(exp_q.size() == 0, "R5 all expected bytes received", exp_q.size(), 0);
    report();
  end
endmodule